// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block sits between an on-chip requester and an external byte-wide asynchronous static RAM with 128K locations. The requester offers one access at a time: a valid strobe, a write flag, a 17-bit address and, for writes, a data byte. The controller then drives the memory's active-low chip enable, write enable and output enable and the address bus. It also runs the bidirectional data pins through a separate output byte, a driver enable and an input byte. Each phase of an access lasts a whole number of clocks, sized so that a 15 ns access budget is met at a 100 MHz clock.

A read keeps chip enable and output enable low for two cycles and samples the data pins at the end of the second one. A write needs a turnaround cycle first. In that cycle chip enable is low and both output enable and write enable are high, so the memory has released the bus before the data drivers switch on. Write enable then stays low for two cycles and rises while chip enable, address and data are held for one more cycle, so the byte is committed on the write enable edge. An acknowledge pulse marks the end of every access. The controller returns to idle in that same cycle, so a held request is accepted at once.

The state machine has five states. `ST_IDLE` leaves on an accepted request, going to `ST_RD_ACCESS` for a read or to `ST_WR_SETUP` for a write. `ST_RD_ACCESS` returns to `ST_IDLE` after its last cycle. `ST_WR_SETUP` moves to `ST_WR_STROBE` after the turnaround cycle. `ST_WR_STROBE` moves to `ST_WR_HOLD` when the write pulse ends. `ST_WR_HOLD` returns to `ST_IDLE` after the hold cycle. A phase timer restarts on every state change and marks the last cycle of the current state.

Top module: `asram_port_ctrl`

## Requirements
- R1: After reset and whenever idle, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `ack` is 0.
- R2: A request is taken only when `req_ready` is 1. A `req_valid` pulse raised while an access is running produces no acknowledge and leaves the memory contents unchanged.
- R3: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly 2 cycles. The data pins are sampled in the second cycle, and `rsp_rdata` carries that byte in the `ack` cycle that follows.
- R4: A write keeps `mem_ce_n`=0 for exactly 4 cycles: 1 cycle with `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0, then 2 cycles with `mem_we_n`=0 and `mem_dq_oe`=1, then 1 cycle with `mem_we_n`=1 and `mem_dq_oe`=1. `mem_oe_n` stays 1 throughout.
- R5: `mem_addr`, and `mem_dq_out` while driven, do not change while `mem_ce_n` stays 0. In particular, both are unchanged across the rising edge of `mem_we_n`.
- R6: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. The drivers switch on only after a cycle in which chip enable was low with output enable and write enable both high.
- R7: `ack` is high for exactly one cycle per completed access. `rsp_rdata` keeps the last read byte until the next read completes, including across writes.
- R8: A request held valid during the `ack` cycle is accepted in that cycle. A read directly after a write, and a write directly after a read, both return correct data without bus contention.
- R9: All 17 address bits reach the memory. Locations 0x00000 and 0x1FFFF are kept apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz assumed |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester offers an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Controller is idle and takes a request this cycle |
| ack | output | 1 | One-cycle pulse when an access completes |
| rsp_rdata | output | 8 | Byte from the last completed read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_out | output | 8 | Byte driven onto the data pins |
| mem_dq_oe | output | 1 | Enable for the data pin drivers |
| mem_dq_in | input | 8 | Byte sampled from the data pins |

## Verification
Two things can happen in the same cycle: the acknowledge of one access and the acceptance of the next. This is provoked by keeping requests queued, so that the driver raises `req_valid` in the very cycle `ack` is high. Write-then-read and read-then-write pairs on the same address go through that path. The result is judged by the scoreboard's in-order data comparison and by a memory model that counts a failure whenever the controller drives the pins while the model's outputs are on. The width of each strobe window is also measured from the pins.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_HOLD
    } ctrl_state_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_QUIET = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Marks the final cycle of the current phase.
    assign last = (cnt_q == limit - CNT_W'(1));

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load) begin
            addr_q  <= load_addr;
            wdata_q <= load_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= dq_in;
        end
    end

    // R7: the read byte only moves on a capture.
    assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture) |-> $stable(rdata_q));

    // R5: the address only moves on a load.
    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> $stable(addr_q));

endmodule

// File: rtl/asram_port_ctrl.sv
module asram_port_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W       = 17,
    parameter int DATA_W       = 8,
    parameter int RD_CYC       = 2,
    parameter int WR_SETUP_CYC = 1,
    parameter int WR_PULSE_CYC = 2,
    parameter int WR_HOLD_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int MAX_AB  = (RD_CYC > WR_SETUP_CYC) ? RD_CYC : WR_SETUP_CYC;
    localparam int MAX_CD  = (WR_PULSE_CYC > WR_HOLD_CYC) ? WR_PULSE_CYC : WR_HOLD_CYC;
    localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    ctrl_state_t      state_q, state_d;
    pin_ctl_t         pins;
    logic             ack_q;
    logic             accept;
    logic             phase_last;
    logic             phase_restart;
    logic             capture;
    logic [CNT_W-1:0] phase_limit;

    assign accept        = (state_q == ST_IDLE) && req_valid;
    assign phase_restart = (state_d != state_q);
    assign capture       = (state_q == ST_RD_ACCESS) && phase_last;

    // State register and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_RD_ACCESS: if (phase_last) state_d = ST_IDLE;
            ST_WR_SETUP:  if (phase_last) state_d = ST_WR_STROBE;
            ST_WR_STROBE: if (phase_last) state_d = ST_WR_HOLD;
            ST_WR_HOLD:   if (phase_last) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Phase length per state
    always_comb begin
        phase_limit = CNT_W'(1);
        unique case (state_q)
            ST_RD_ACCESS: phase_limit = CNT_W'(RD_CYC);
            ST_WR_SETUP:  phase_limit = CNT_W'(WR_SETUP_CYC);
            ST_WR_STROBE: phase_limit = CNT_W'(WR_PULSE_CYC);
            ST_WR_HOLD:   phase_limit = CNT_W'(WR_HOLD_CYC);
            default:      phase_limit = CNT_W'(1);
        endcase
    end

    // Output decode
    always_comb begin
        pins = PINS_QUIET;
        unique case (state_q)
            ST_IDLE:      pins = PINS_QUIET;
            ST_RD_ACCESS: pins = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
            ST_WR_SETUP:  pins = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
            ST_WR_STROBE: pins = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
            ST_WR_HOLD:   pins = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
            default:      pins = PINS_QUIET;
        endcase
    end

    assign mem_ce_n  = pins.ce_n;
    assign mem_we_n  = pins.we_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_dq_oe = pins.dq_oe;
    assign req_ready = (state_q == ST_IDLE);
    assign ack       = ack_q;

    asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (phase_restart),
        .limit   (phase_limit),
        .last    (phase_last)
    );

    asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_addr  (req_addr),
        .load_wdata (req_wdata),
        .capture    (capture),
        .dq_in      (mem_dq_in),
        .addr_q     (mem_addr),
        .wdata_q    (mem_dq_out),
        .rdata_q    (rsp_rdata)
    );

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_no_bus_fight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_turnaround_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(!mem_ce_n && mem_oe_n && mem_we_n));

    assert_read_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    assert_pulse_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe && !mem_ce_n));

    assert_commit_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr)));

    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_busy_ignores_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && req_valid) |=> $stable(mem_addr));

endmodule

// File: tb/asram_port_ctrl_tb.sv
module asram_port_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam logic [DW-1:0] BLANK = 8'hA5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, ack;
    logic [DW-1:0] rsp_rdata;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asram_port_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .ack(ack), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural memory ----------------
    logic [DW-1:0] store [int];
    logic          model_on;
    logic          prev_we_n = 1'b1;

    assign model_on = !mem_ce_n && !mem_oe_n && mem_we_n;

    always @* begin
        if (model_on) mem_dq_in = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : BLANK;
        else          mem_dq_in = 8'h00;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && model_on)
                check(1'b0, "R6 bus contention", 1, 0);
            if (!prev_we_n && mem_we_n && !mem_ce_n) begin
                check(mem_dq_oe, "R4/R5 data driven at commit", int'(mem_dq_oe), 1);
                store[int'(mem_addr)] = mem_dq_out;
            end
        end
        prev_we_n = mem_we_n;
    end

    // ---------------- strobe window monitor ----------------
    bit in_acc = 1'b0;
    int n_ce, n_oe, n_we, first_dq;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n) begin
                if (!in_acc) begin
                    in_acc = 1'b1; n_ce = 0; n_oe = 0; n_we = 0; first_dq = -1;
                end
                if (!mem_oe_n) n_oe++;
                if (!mem_we_n) n_we++;
                if (mem_dq_oe && first_dq < 0) first_dq = n_ce;
                n_ce++;
            end else if (in_acc) begin
                in_acc = 1'b0;
                if (n_we > 0) begin
                    check(n_ce == 4, "R4 write ce window", n_ce, 4);
                    check(n_we == 2, "R4 write pulse", n_we, 2);
                    check(first_dq == 1, "R4/R6 driver start", first_dq, 1);
                    check(n_oe == 0, "R4 oe during write", n_oe, 0);
                end else begin
                    check(n_ce == 2, "R3 read ce window", n_ce, 2);
                    check(n_oe == 2, "R3 read oe window", n_oe, 2);
                    check(first_dq == -1, "R3/R6 no drive on read", first_dq, -1);
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit            wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } item_t;

    item_t         sb_q [$];
    logic [DW-1:0] shadow [int];
    logic [DW-1:0] last_rd = '0;
    bit            prev_ack = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ack) begin
                check(!prev_ack, "R7 ack width", 2, 1);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2 unexpected ack", 1, 0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    if (it.wr) begin
                        check(rsp_rdata == last_rd, "R7 rdata held over write", int'(rsp_rdata), int'(last_rd));
                    end else begin
                        check(rsp_rdata == it.data, "R3/R8/R9 read data", int'(rsp_rdata), int'(it.data));
                        last_rd = rsp_rdata;
                    end
                end
            end
            prev_ack = ack;
        end
    end

    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        item_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        it.wr = wr; it.addr = a;
        if (wr) begin
            shadow[int'(a)] = d;
            it.data = d;
        end else begin
            it.data = shadow.exists(int'(a)) ? shadow[int'(a)] : BLANK;
        end
        sb_q.push_back(it);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // R2: pulse a request while the controller is busy
    task automatic busy_pulse(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        check(!req_ready, "R2 controller busy", int'(req_ready), 0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
        check(!mem_dq_oe, "R1 drivers off", int'(mem_dq_oe), 0);
        check(req_ready && !ack, "R1 ready no ack", {req_ready, ack}, 2);

        // R9 address extremes
        issue(1'b1, 17'h00000, 8'h3C);
        issue(1'b1, 17'h1FFFF, 8'hC3);
        issue(1'b0, 17'h00000, 8'h00);
        issue(1'b0, 17'h1FFFF, 8'h00);

        // R8 back-to-back turnarounds on one address
        issue(1'b1, 17'h0ABCD, 8'h5A);
        issue(1'b0, 17'h0ABCD, 8'h00);
        issue(1'b1, 17'h0ABCD, 8'hE1);
        issue(1'b0, 17'h0ABCD, 8'h00);

        // R2 request during a busy write is dropped
        issue(1'b1, 17'h00010, 8'h11);
        busy_pulse(17'h00020, 8'hFF);
        issue(1'b0, 17'h00020, 8'h00);
        issue(1'b0, 17'h00010, 8'h00);

        // Several patterns: walking address bits and varied data
        for (int i = 0; i < AW; i++) issue(1'b1, 17'(1) << i, 8'(i * 37 + 3));
        for (int i = 0; i < AW; i++) issue(1'b0, 17'(1) << i, 8'h00);

        // R7 held rdata across writes after a read
        issue(1'b0, 17'h1FFFF, 8'h00);
        issue(1'b1, 17'h00003, 8'h77);
        issue(1'b1, 17'h00004, 8'h88);

        while (sb_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(req_ready && mem_ce_n && !mem_dq_oe, "R1 back to idle", {req_ready, mem_ce_n, mem_dq_oe}, 6);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule